// File: doc/BRIEF.md
# Tile Edge Anti-Alias Resolver

This block runs once for each tile, after rasterisation of that tile has finished. It walks every pixel of the tile. A pixel whose tag marks it as a partially covered edge pixel gets a new colour: its own colour is mixed with the colour of one orthogonal neighbour, or with two neighbours in one case. The edge direction stored in the tag picks the neighbour, and the error terms stored in the tag set the mix ratio. A pixel with no edge flags is never written.

The resolver connects to the tile's colour and tag memories through a read port with one cycle of latency and a colour write port. A one-cycle `start` pulse begins a pass. The pass has two phases. The load phase reads every pixel once, in ascending address order, into a private snapshot. The resolve phase then visits each pixel in ascending order and issues a write only for tagged pixels. Every blend reads its neighbours from the snapshot, so a neighbour that has already been rewritten still contributes its pre-pass colour. `done` pulses for one cycle when the pass ends.

Tag layout (16 bits):
- bits [3:0] hold the edge flags: left, right, up and down, in bit order 0 to 3.
- bits [8:4] hold the horizontal error.
- bits [13:9] hold the vertical error.
- bit [14] marks low coverage.
- bit [15] is unused.

Colour is `N_CH` channels of `CH_W` bits, with channel 0 in the least significant bits.

Top module: `aa_tile_resolver`

## Requirements
- R1: After `start` in idle, the block asserts `rd_en` for exactly W·H consecutive cycles with `rd_addr` going 0,1,…,W·H−1. Read data is taken one cycle after each request.
- R2: A pixel whose tag is all zero is never written; its memory colour stays as it was.
- R3: For a single edge flag, the neighbour is left (x−1), right (x+1), up (y−1) or down (y+1). The weight w is the horizontal error (bits [8:4]) for left/right and the vertical error (bits [13:9]) for up/down. Each channel becomes (w·own + (32−w)·neighbour) >> 5.
- R4: When bit 14 is set, own and neighbour swap roles: each channel becomes (w·neighbour + (32−w)·own) >> 5.
- R5: When both left and right flags are set, the neighbour colour is the per-channel average (left+right)>>1 and w is the horizontal error.
- R6: Otherwise, with several flags set, the flag with the lowest bit position wins (left, then right, then up, then down).
- R7: A neighbour outside the tile is replaced by the pixel's own colour.
- R8: Blends always use the colours as they were before the pass, even if that neighbour has already been rewritten.
- R9: Writes occur in ascending address order and never overlap reads. `done` is high for exactly one cycle per pass, in the cycle of the last possible write. `start` during a pass is ignored.
- R10: During and directly after reset, `rd_en`, `wr_en` and `done` are low.
- R11: A non-zero tag with all four edge flags clear is not written, and bit 15 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (honoured in idle only) |
| done | output | 1 | One-cycle end-of-pass pulse |
| rd_en | output | 1 | Read request to colour and tag memories |
| rd_addr | output | TILE_W_LOG2+TILE_H_LOG2 | Pixel address, row-major |
| rd_colour | input | CH_W·N_CH | Colour returned one cycle after request |
| rd_tag | input | 16 | Tag returned one cycle after request |
| wr_en | output | 1 | Colour write strobe |
| wr_addr | output | TILE_W_LOG2+TILE_H_LOG2 | Write pixel address |
| wr_colour | output | CH_W·N_CH | Resolved colour |

## Verification
The assertions rely on two properties of the environment. The memories return read data exactly one cycle after a request, and nothing else writes the tile while a pass is running. The bench memory model meets both: it answers every request on the next edge, and it changes its contents only through the block's own write port. The bench drives `start` as single-cycle pulses, sometimes in the middle of a pass, and changes tile contents only between passes.

// File: rtl/aa_pkg.sv
package aa_pkg;
    localparam int TAG_W      = 16;
    localparam int ERR_W      = 5;
    localparam int XERR_LO    = 4;
    localparam int YERR_LO    = 9;
    localparam int LOWCOV_BIT = 14;
    localparam int KEEP_W     = 15;   // tag bits kept in the snapshot

    typedef enum logic [1:0] {NB_LEFT, NB_RIGHT, NB_UP, NB_DOWN} nb_sel_e;
    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RESOLVE, ST_DONE} phase_e;
endpackage

// File: rtl/aa_tag_decode.sv
module aa_tag_decode
    import aa_pkg::*;
(
    input  logic [KEEP_W-1:0] tag,
    output logic              active,
    output logic              dual,
    output nb_sel_e           sel,
    output logic [ERR_W-1:0]  weight,
    output logic              swap
);
    logic [3:0] edges;

    always_comb begin
        edges  = tag[3:0];
        active = |edges;
        dual   = edges[0] & edges[1];
        if (edges[0])      sel = NB_LEFT;
        else if (edges[1]) sel = NB_RIGHT;
        else if (edges[2]) sel = NB_UP;
        else               sel = NB_DOWN;
        weight = (sel == NB_UP || sel == NB_DOWN) ? tag[YERR_LO +: ERR_W]
                                                  : tag[XERR_LO +: ERR_W];
        swap   = tag[LOWCOV_BIT];
    end
endmodule

// File: rtl/aa_mix.sv
module aa_mix
    import aa_pkg::*;
#(
    parameter int CH_W = 8,
    parameter int N_CH = 3
) (
    input  logic [CH_W*N_CH-1:0] own,
    input  logic [CH_W*N_CH-1:0] nbr_a,
    input  logic [CH_W*N_CH-1:0] nbr_b,
    input  logic                 dual,
    input  logic                 swap,
    input  logic [ERR_W-1:0]     weight,
    output logic [CH_W*N_CH-1:0] mixed
);
    localparam int ACC_W = CH_W + ERR_W + 1;

    logic [ERR_W:0] w_fg, w_bg;
    assign w_fg = {1'b0, weight};
    assign w_bg = (ERR_W+1)'(1 << ERR_W) - w_fg;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [CH_W:0]   pair_sum;
        logic [CH_W-1:0] under, fg, bg, own_c;
        logic [ACC_W-1:0] acc;
        always_comb begin
            own_c    = own[c*CH_W +: CH_W];
            pair_sum = {1'b0, nbr_a[c*CH_W +: CH_W]} + {1'b0, nbr_b[c*CH_W +: CH_W]};
            under    = dual ? pair_sum[CH_W:1] : nbr_a[c*CH_W +: CH_W];
            fg       = swap ? under : own_c;
            bg       = swap ? own_c : under;
            acc      = ACC_W'(w_fg) * ACC_W'(fg) + ACC_W'(w_bg) * ACC_W'(bg);
            mixed[c*CH_W +: CH_W] = acc[ERR_W +: CH_W];
        end
    end
endmodule

// File: rtl/aa_tile_resolver.sv
module aa_tile_resolver
    import aa_pkg::*;
#(
    parameter int TILE_W_LOG2 = 3,
    parameter int TILE_H_LOG2 = 3,
    parameter int CH_W        = 8,
    parameter int N_CH        = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    output logic                                done,
    output logic                                rd_en,
    output logic [TILE_W_LOG2+TILE_H_LOG2-1:0]  rd_addr,
    input  logic [CH_W*N_CH-1:0]                rd_colour,
    input  logic [TAG_W-1:0]                    rd_tag,
    output logic                                wr_en,
    output logic [TILE_W_LOG2+TILE_H_LOG2-1:0]  wr_addr,
    output logic [CH_W*N_CH-1:0]                wr_colour
);
    localparam int TW    = 1 << TILE_W_LOG2;
    localparam int AW    = TILE_W_LOG2 + TILE_H_LOG2;
    localparam int NPIX  = 1 << AW;
    localparam int CNT_W = AW + 1;
    localparam int PIX_W = CH_W * N_CH;

    typedef struct packed {
        phase_e                         phase;
        logic [CNT_W-1:0]               cnt;
        logic                           cap_v;
        logic [AW-1:0]                  cap_a;
        logic [NPIX-1:0][PIX_W-1:0]     col;
        logic [NPIX-1:0][KEEP_W-1:0]    tag;
        logic                           wr_en;
        logic [AW-1:0]                  wr_addr;
        logic [PIX_W-1:0]               wr_col;
    } state_t;

    state_t q, d;

    // bit 15 of the tag carries no meaning
    logic rsvd_unused;
    assign rsvd_unused = rd_tag[TAG_W-1];

    // current pixel and its neighbourhood
    logic [AW-1:0]          idx, i_l, i_r, i_u, i_d;
    logic [TILE_W_LOG2-1:0] px;
    logic [TILE_H_LOG2-1:0] py;
    logic [PIX_W-1:0]       own, c_l, c_r, c_u, c_d, nbr_a, mix_out;
    logic                   dec_active, dec_dual, dec_swap;
    nb_sel_e                dec_sel;
    logic [ERR_W-1:0]       dec_w;

    always_comb begin
        idx = q.cnt[AW-1:0];
        px  = idx[TILE_W_LOG2-1:0];
        py  = idx[AW-1:TILE_W_LOG2];
        i_l = idx - AW'(1);
        i_r = idx + AW'(1);
        i_u = idx - AW'(TW);
        i_d = idx + AW'(TW);
        own = q.col[idx];
        c_l = (px == '0) ? own : q.col[i_l];
        c_r = (px == '1) ? own : q.col[i_r];
        c_u = (py == '0) ? own : q.col[i_u];
        c_d = (py == '1) ? own : q.col[i_d];
        unique case (dec_sel)
            NB_LEFT:  nbr_a = c_l;
            NB_RIGHT: nbr_a = c_r;
            NB_UP:    nbr_a = c_u;
            default:  nbr_a = c_d;
        endcase
    end

    aa_tag_decode u_dec (
        .tag    (q.tag[idx]),
        .active (dec_active),
        .dual   (dec_dual),
        .sel    (dec_sel),
        .weight (dec_w),
        .swap   (dec_swap)
    );

    aa_mix #(.CH_W(CH_W), .N_CH(N_CH)) u_mix (
        .own    (own),
        .nbr_a  (nbr_a),
        .nbr_b  (c_r),
        .dual   (dec_dual),
        .swap   (dec_swap),
        .weight (dec_w),
        .mixed  (mix_out)
    );

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        d.cap_v = 1'b0;
        unique case (q.phase)
            ST_IDLE: begin
                if (start) begin
                    d.phase = ST_LOAD;
                    d.cnt   = '0;
                end
            end
            ST_LOAD: begin
                if (q.cnt < CNT_W'(NPIX)) begin
                    d.cnt   = q.cnt + 1'b1;
                    d.cap_v = 1'b1;
                    d.cap_a = q.cnt[AW-1:0];
                end
                if (q.cap_v) begin
                    d.col[q.cap_a] = rd_colour;
                    d.tag[q.cap_a] = rd_tag[KEEP_W-1:0];
                    if (q.cap_a == AW'(NPIX - 1)) begin
                        d.phase = ST_RESOLVE;
                        d.cnt   = '0;
                    end
                end
            end
            ST_RESOLVE: begin
                if (dec_active) begin
                    d.wr_en   = 1'b1;
                    d.wr_addr = idx;
                    d.wr_col  = mix_out;
                end
                if (idx == AW'(NPIX - 1)) d.phase = ST_DONE;
                else                      d.cnt   = q.cnt + 1'b1;
            end
            default: d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_en     = (q.phase == ST_LOAD) && (q.cnt < CNT_W'(NPIX));
    assign rd_addr   = q.cnt[AW-1:0];
    assign wr_en     = q.wr_en;
    assign wr_addr   = q.wr_addr;
    assign wr_colour = q.wr_col;
    assign done      = (q.phase == ST_DONE);

    // ---------------- assertions ----------------
    a_r1_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> rd_addr == '0);

    a_r1_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && $past(rd_en) |-> rd_addr == AW'($past(rd_addr) + 1'b1));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_en);

    a_r9_write_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr > $past(wr_addr));

    // R7: with every neighbour equal to the pixel, the mix must return it
    always_comb begin
        if (rst_n && q.phase == ST_RESOLVE && dec_active && nbr_a == own && c_r == own)
            a_r7_border_identity: assert (mix_out == own)
                else $error("a_r7_border_identity");
    end
endmodule

// File: tb/aa_tile_resolver_test.sv
`timescale 1ns/1ps
module aa_tile_resolver_test;
    localparam int W    = 8;
    localparam int H    = 8;
    localparam int NPIX = W * H;
    localparam int AW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [23:0]   rd_colour = '0, wr_colour;
    logic [15:0]   rd_tag = '0;

    always #2 clk = ~clk;   // 250 MHz

    aa_tile_resolver uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_colour(rd_colour), .rd_tag(rd_tag),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_colour(wr_colour)
    );

    logic [23:0] col_mem [NPIX];
    logic [15:0] tag_mem [NPIX];
    logic [23:0] orig_col [NPIX];
    logic [15:0] orig_tag [NPIX];

    always @(posedge clk) begin
        if (rd_en) begin
            rd_colour <= col_mem[rd_addr];
            rd_tag    <= tag_mem[rd_addr];
        end
        if (wr_en) col_mem[wr_addr] <= wr_colour;
    end

    typedef struct {
        int          addr;
        logic [23:0] col;
        logic [15:0] tag;
    } exp_t;
    exp_t sb_q[$];
    exp_t cur;

    int checks = 0;
    int errors = 0;
    int rd_seen = 0;
    int done_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [15:0] t);
        if (t[0] && t[1])          return "R5";
        if (t[14])                 return "R4";
        if ($countones(t[3:0]) > 1) return "R6";
        return "R3";
    endfunction

    // independent model of the requirements
    function automatic logic [23:0] ref_pixel(input int i);
        int x = i % W;
        int y = i / W;
        logic [23:0] own = orig_col[i];
        logic [15:0] t = orig_tag[i];
        logic [23:0] lf, rt, up, dn, r;
        int w, o, nb, fg, bg;
        lf = (x == 0)     ? own : orig_col[i-1];
        rt = (x == W - 1) ? own : orig_col[i+1];
        up = (y == 0)     ? own : orig_col[i-W];
        dn = (y == H - 1) ? own : orig_col[i+W];
        w  = (t[0] || t[1]) ? int'(t[8:4]) : int'(t[13:9]);
        r  = own;
        for (int c = 0; c < 3; c++) begin
            o = int'(own[c*8 +: 8]);
            if (t[0] && t[1]) nb = (int'(lf[c*8 +: 8]) + int'(rt[c*8 +: 8])) / 2;
            else if (t[0])    nb = int'(lf[c*8 +: 8]);
            else if (t[1])    nb = int'(rt[c*8 +: 8]);
            else if (t[2])    nb = int'(up[c*8 +: 8]);
            else              nb = int'(dn[c*8 +: 8]);
            fg = t[14] ? nb : o;
            bg = t[14] ? o : nb;
            r[c*8 +: 8] = 8'((w * fg + (32 - w) * bg) / 32);
        end
        return r;
    endfunction

    // monitor: pops the scoreboard as writes appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) rd_seen++;
            if (done)  done_seen++;
            if (wr_en) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected write", wr_colour, 24'h0);
                end else begin
                    cur = sb_q.pop_front();
                    chk(int'(wr_addr) == cur.addr, "R9", "write address",
                        24'(wr_addr), 24'(cur.addr));
                    chk(wr_colour == cur.col, req_of(cur.tag), "resolved colour",
                        wr_colour, cur.col);
                end
            end
        end
    end

    task automatic snapshot();
        for (int i = 0; i < NPIX; i++) begin
            orig_col[i] = col_mem[i];
            orig_tag[i] = tag_mem[i];
        end
    endtask

    task automatic run_tile(input bit poke);
        snapshot();
        for (int i = 0; i < NPIX; i++)
            if (orig_tag[i][3:0] != 4'h0)
                sb_q.push_back('{i, ref_pixel(i), orig_tag[i]});
        rd_seen   = 0;
        done_seen = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(rd_seen == NPIX, "R1", "read count", 24'(rd_seen), 24'(NPIX));
        chk(done_seen == 1, "R9", "done pulses", 24'(done_seen), 24'd1);
        chk(sb_q.size() == 0, "R3", "writes outstanding", 24'(sb_q.size()), 24'd0);
        sb_q.delete();
        for (int i = 0; i < NPIX; i++)
            if (orig_tag[i][3:0] == 4'h0)
                chk(col_mem[i] == orig_col[i], (orig_tag[i] == 16'h0) ? "R2" : "R11",
                    "untouched pixel", col_mem[i], orig_col[i]);
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] v = s;
        v = v ^ (v << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic fill_random(input logic [31:0] seed);
        logic [31:0] s = seed;
        for (int i = 0; i < NPIX; i++) begin
            s = step(s);
            col_mem[i] = s[23:0];
            s = step(s);
            tag_mem[i] = (s[2:0] < 3'd2) ? 16'h0 : s[31:16];
        end
    endtask

    task automatic tests();
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R10", "outputs in reset",
            {21'h0, rd_en, wr_en, done}, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R10", "outputs after reset",
            {21'h0, rd_en, wr_en, done}, 24'h0);

        // R2: all-zero tags, no writes
        fill_random(32'h1234_5678);
        for (int i = 0; i < NPIX; i++) tag_mem[i] = 16'h0;
        run_tile(1'b0);

        // directed corner cases
        for (int i = 0; i < NPIX; i++) begin
            col_mem[i] = 24'h0;
            tag_mem[i] = 16'h0;
        end
        col_mem[9]  = 24'h0000FF; tag_mem[9]  = 16'h0081;   // left, xerr 8
        col_mem[20] = 24'h0000FF; tag_mem[20] = 16'h5004;   // up, yerr 8, low coverage
        col_mem[34] = 24'h000064; col_mem[36] = 24'h0000C8;
        tag_mem[35] = 16'h0103;                             // left+right, xerr 16
        col_mem[49] = 24'h123456; tag_mem[49] = 16'h0002;   // right, xerr 0
        col_mem[50] = 24'hABCDEF; tag_mem[50] = 16'h0009;   // left+down, xerr 0
        col_mem[0]  = 24'h55AA33; tag_mem[0]  = 16'h0051;   // left at tile border
        col_mem[60] = 24'h777777; tag_mem[60] = 16'h81F0;   // no flags, bit 15 set
        run_tile(1'b0);
        chk(col_mem[9]  == 24'h00003F, "R3", "hand blend", col_mem[9], 24'h00003F);
        chk(col_mem[20] == 24'h0000BF, "R4", "swapped blend", col_mem[20], 24'h0000BF);
        chk(col_mem[35] == 24'h00004B, "R5", "dual blend", col_mem[35], 24'h00004B);
        chk(col_mem[49] == 24'hABCDEF, "R8", "original right neighbour", col_mem[49], 24'hABCDEF);
        chk(col_mem[50] == 24'h123456, "R6", "left wins over down", col_mem[50], 24'h123456);
        chk(col_mem[0]  == 24'h55AA33, "R7", "border keeps own", col_mem[0], 24'h55AA33);

        // pseudo-random tiles, second one with a start pulse mid-pass
        fill_random(32'hCAFE_0001);
        run_tile(1'b0);
        fill_random(32'h0BAD_F00D);
        run_tile(1'b1);
    endtask

    initial begin
        fork
            tests();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R9 watchdog actual timeout expected done");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule